// File: doc/BRIEF.md
# DAC Sample Feed and Start Controller

This block sits between a bus write port and the code input of a digital-to-analog converter. Software pushes sample codes into a small first-in first-out queue. A 16-bit write carries a 12-bit code in its upper twelve bits. A selectable trigger then starts output. Once started, the block either mirrors each new sample straight to the output and holds it (static mode), or pops one sample per programmable interval (paced mode).

The trigger can be any of three events: the queue holding data, a software start bit, or a start strobe shared with the ADC so that several converters begin on the same clock. Starting is one-way. After the block leaves the idle state, further triggers are ignored until reset. The operating mode is captured at the moment of starting. Sticky flags record a write lost to a full queue and a paced pop that found the queue empty.

The controller has three states. ST_IDLE waits for the selected trigger. When the trigger is seen, the transition goes to ST_STATIC if the operating mode is 00, and to ST_PACED otherwise. ST_STATIC and ST_PACED hold until reset. ST_STATIC pops whenever the queue is non-empty. ST_PACED pops on each tick of the rate timer.

Top module: `dac_feed_ctrl`

## Requirements
- R1: Synchronous active-high `rst` empties the queue, returns to ST_IDLE, and clears `code_out`, `code_valid`, `underrun`, `overflow` and the software start bit.
- R2: With `start_mode` = 00, the block leaves ST_IDLE on the first clock edge at which the queue is non-empty.
- R3: With `start_mode` = 10, `sw_start` high at edge S sets a start bit that clears itself at the next edge. The block leaves ST_IDLE at edge S+1. Other triggers are ignored in this mode.
- R4: With `start_mode` = 01, `adc_start` high at an edge moves the block out of ST_IDLE at that edge. `sw_start` is ignored in this mode.
- R5: In ST_STATIC, a sample present in the queue is popped at the next edge, drives `code_out` and sets `code_valid`. The code is held until another sample arrives. `rate` has no effect.
- R6: With CODE_W = 12, the output code of a sample is `wr_data[15:4]` and `wr_data[3:0]` are discarded.
- R7: In ST_PACED, entered at edge E, pops occur at edges E+RATE+1, E+2(RATE+1), and so on.
- R8: A paced pop time that finds the queue empty holds `code_out` and sets the sticky `underrun`. A write in that same cycle is queued and is output at the next pop time.
- R9: The queue holds DEPTH = 8 samples in arrival order. `fifo_full` and `fifo_empty` report its occupancy.
- R10: A write while `fifo_full` is high is dropped, even if a pop occurs in that cycle, and it sets the sticky `overflow`.
- R11: Any trigger that arrives after the block has left ST_IDLE is ignored, and the paced cadence continues unchanged.
- R12: `start_mode` = 11 never starts output. The block stays in ST_IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample write data |
| start_mode | input | 2 | Trigger select: 00 queue non-empty, 01 ADC strobe, 10 software bit, 11 none |
| op_mode | input | 2 | 00 static, any other value paced |
| sw_start | input | 1 | Write of 1 to the software start bit |
| adc_start | input | 1 | Shared start strobe from the ADC |
| rate | input | RATE_W (8) | Paced interval minus one, in clocks |
| code_out | output | CODE_W (12) | Code presented to the converter |
| code_valid | output | 1 | High once a first code has been output |
| fifo_full | output | 1 | Queue holds DEPTH samples |
| fifo_empty | output | 1 | Queue holds no sample |
| underrun | output | 1 | Sticky: a paced pop found the queue empty |
| overflow | output | 1 | Sticky: a write was dropped on a full queue |

## Verification
Two collisions get the closest attention. The first is a paced pop time falling on an empty queue in the same cycle that a new sample is written. The bench writes exactly on that edge and checks three things: `underrun` rises, the old code holds, and the new sample appears one full interval later. The second is a trigger arriving while output is already running. The bench pulses both `sw_start` and `adc_start` mid-interval and confirms that the next pop lands on the original cadence.

// File: rtl/dac_feed_pkg.sv
package dac_feed_pkg;

    typedef enum logic [1:0] {
        TRIG_FIFO = 2'b00,
        TRIG_ADC  = 2'b01,
        TRIG_SW   = 2'b10,
        TRIG_NONE = 2'b11
    } start_trig_t;

    localparam logic [1:0] OP_STATIC = 2'b00;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_STATIC = 2'b01,
        ST_PACED  = 2'b10
    } run_state_t;

endpackage

// File: rtl/dac_code_unpack.sv
module dac_code_unpack #(
    parameter int CODE_W = 12
) (
    input  logic [15:0]       bus_word,
    output logic [CODE_W-1:0] code
);
    generate
        if (CODE_W == 12) begin : g_wide
            // code occupies the top twelve bits; bottom nibble is padding
            assign code = bus_word[15:4];
            logic pad_unused;
            assign pad_unused = ^bus_word[3:0];
        end else begin : g_byte
            assign code = bus_word[CODE_W-1:0];
            logic pad_unused;
            assign pad_unused = ^bus_word[15:CODE_W];
        end
    endgenerate
endmodule

// File: rtl/dac_sample_fifo.sv
module dac_sample_fifo #(
    parameter int WIDTH = 12,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             full,
    output logic             empty
);
    localparam int PTR_W = $clog2(DEPTH);

    logic [WIDTH-1:0] slots [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [PTR_W:0]   fill;

    assign full  = (fill == DEPTH[PTR_W:0]);
    assign empty = (fill == '0);
    assign head  = slots[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                slots[wr_ptr] <= push_data;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (pop) rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/dac_rate_timer.sv
module dac_rate_timer #(
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [RATE_W-1:0] rate,
    output logic              tick
);
    logic [RATE_W-1:0] cnt;

    assign tick = run && (cnt == rate);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/dac_feed_ctrl.sv
module dac_feed_ctrl
    import dac_feed_pkg::*;
#(
    parameter int CODE_W = 12,
    parameter int DEPTH  = 8,
    parameter int RATE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    input  logic [1:0]        start_mode,
    input  logic [1:0]        op_mode,
    input  logic              sw_start,
    input  logic              adc_start,
    input  logic [RATE_W-1:0] rate,
    output logic [CODE_W-1:0] code_out,
    output logic              code_valid,
    output logic              fifo_full,
    output logic              fifo_empty,
    output logic              underrun,
    output logic              overflow
);
    run_state_t        state, state_nxt;
    logic              start_bit;
    logic              start_hit;
    logic              tick;
    logic              push, pop;
    logic [CODE_W-1:0] new_code, head_code;
    logic              in_idle;

    assign in_idle = (state == ST_IDLE);
    assign push    = wr_en && !fifo_full;
    assign pop     = !fifo_empty &&
                     ((state == ST_STATIC) || (state == ST_PACED && tick));

    dac_code_unpack #(.CODE_W(CODE_W)) u_unpack (
        .bus_word (wr_data),
        .code     (new_code)
    );

    dac_sample_fifo #(.WIDTH(CODE_W), .DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_data (new_code),
        .pop       (pop),
        .head      (head_code),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    dac_rate_timer #(.RATE_W(RATE_W)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_PACED),
        .rate (rate),
        .tick (tick)
    );

    // trigger decode
    always_comb begin
        unique case (start_mode)
            TRIG_FIFO: start_hit = !fifo_empty;
            TRIG_ADC:  start_hit = adc_start;
            TRIG_SW:   start_hit = start_bit;
            default:   start_hit = 1'b0;
        endcase
    end

    // next-state logic
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_hit)
                    state_nxt = (op_mode == OP_STATIC) ? ST_STATIC : ST_PACED;
            end
            ST_STATIC: state_nxt = ST_STATIC;
            ST_PACED:  state_nxt = ST_PACED;
            default:   state_nxt = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nxt;
    end

    // outputs and flags
    always_ff @(posedge clk) begin
        if (rst) begin
            code_out   <= '0;
            code_valid <= 1'b0;
            underrun   <= 1'b0;
            overflow   <= 1'b0;
            start_bit  <= 1'b0;
        end else begin
            start_bit <= sw_start;
            if (pop) begin
                code_out   <= head_code;
                code_valid <= 1'b1;
            end
            if (wr_en && fifo_full)
                overflow <= 1'b1;
            if (state == ST_PACED && tick && fifo_empty)
                underrun <= 1'b1;
        end
    end
endmodule

// File: rtl/dac_feed_chk.sv
module dac_feed_chk #(
    parameter int CODE_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [1:0]        start_mode,
    input logic [CODE_W-1:0] code_out,
    input logic              code_valid,
    input logic              fifo_full,
    input logic              fifo_empty,
    input logic              underrun,
    input logic              overflow,
    input logic              in_idle
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (code_out == '0) && !code_valid && fifo_empty && !overflow && !underrun);

    // R10
    overflow_set_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && fifo_full) |=> overflow);

    // R10
    overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    // R8
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);

    // R9
    full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fifo_full && fifo_empty));

    // R12
    reserved_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (start_mode == 2'b11 && in_idle) |=> in_idle);

    // R7
    code_from_queue_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(code_out) && !$past(rst)) |-> $past(!fifo_empty));
endmodule

bind dac_feed_ctrl dac_feed_chk #(.CODE_W(CODE_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .start_mode (start_mode),
    .code_out   (code_out),
    .code_valid (code_valid),
    .fifo_full  (fifo_full),
    .fifo_empty (fifo_empty),
    .underrun   (underrun),
    .overflow   (overflow),
    .in_idle    (in_idle)
);

// File: tb/dac_feed_ctrl_test.sv
module dac_feed_ctrl_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en;
    logic [15:0] wr_data;
    logic [1:0]  start_mode;
    logic [1:0]  op_mode;
    logic        sw_start;
    logic        adc_start;
    logic [7:0]  rate;
    logic [11:0] code_out;
    logic        code_valid, fifo_full, fifo_empty, underrun, overflow;

    int checks = 0;
    int fails  = 0;

    dac_feed_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .start_mode(start_mode), .op_mode(op_mode), .sw_start(sw_start),
        .adc_start(adc_start), .rate(rate), .code_out(code_out),
        .code_valid(code_valid), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
        .underrun(underrun), .overflow(overflow)
    );

    always #5 clk = ~clk;

    // {bus word, expected code}
    localparam logic [27:0] VEC [0:4] = '{
        {16'hABC0, 12'hABC},
        {16'h0010, 12'h001},
        {16'hFFF0, 12'hFFF},
        {16'h800F, 12'h800},
        {16'h1235, 12'h123}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; sw_start = 1'b0; adc_start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write_word(input logic [15:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        start_mode = 2'b00; op_mode = 2'b00; rate = 8'd200;
        do_reset();
        chk("R1 code", code_out, 0);
        chk("R1 valid", code_valid, 0);
        chk("R1 empty", fifo_empty, 1);
        chk("R1 flags", {fifo_full, underrun, overflow}, 0);

        // table: static mode, trigger on non-empty, large rate ignored
        for (int i = 0; i < 5; i++) begin
            write_word(VEC[i][27:12]);
            repeat (2) @(negedge clk);
            chk("R6 R5 R2 code", code_out, VEC[i][11:0]);
            chk("R5 valid", code_valid, 1);
            chk("R5 drained", fifo_empty, 1);
        end
        repeat (5) @(negedge clk);
        chk("R5 hold", code_out, 12'h123);

        // software start, paced, rate 3
        do_reset();
        start_mode = 2'b10; op_mode = 2'b01; rate = 8'd3;
        write_word(16'h1000); write_word(16'h2000); write_word(16'h3000);
        adc_start = 1'b1;
        repeat (5) @(negedge clk);
        adc_start = 1'b0;
        chk("R3 no start yet", code_valid, 0);
        sw_start = 1'b1;
        @(negedge clk);                 // past edge S
        sw_start = 1'b0;
        repeat (4) @(negedge clk);      // past S+4
        chk("R7 before first pop", code_valid, 0);
        @(negedge clk);                 // past S+5
        chk("R3 R7 first pop", code_out, 12'h100);
        sw_start = 1'b1; adc_start = 1'b1;
        @(negedge clk);                 // past S+6
        sw_start = 1'b0; adc_start = 1'b0;
        repeat (2) @(negedge clk);      // past S+8
        chk("R11 held", code_out, 12'h100);
        @(negedge clk);                 // past S+9
        chk("R11 R7 second pop", code_out, 12'h200);
        repeat (4) @(negedge clk);      // past S+13
        chk("R7 third pop", code_out, 12'h300);
        repeat (3) @(negedge clk);      // past S+16
        chk("R8 no underrun yet", underrun, 0);
        write_word(16'h4000);           // lands on S+17 pop time
        chk("R8 underrun", underrun, 1);
        chk("R8 held", code_out, 12'h300);
        chk("R8 queued", fifo_empty, 0);
        repeat (4) @(negedge clk);      // past S+21
        chk("R8 late sample", code_out, 12'h400);

        // ADC strobe, rate 0
        do_reset();
        start_mode = 2'b01; op_mode = 2'b01; rate = 8'd0;
        write_word(16'h0550); write_word(16'h0660);
        sw_start = 1'b1;
        @(negedge clk);
        sw_start = 1'b0;
        repeat (4) @(negedge clk);
        chk("R4 sw ignored", code_valid, 0);
        adc_start = 1'b1;
        @(negedge clk);
        adc_start = 1'b0;
        chk("R4 entry no pop", code_valid, 0);
        @(negedge clk);
        chk("R4 R7 first", code_out, 12'h055);
        @(negedge clk);
        chk("R7 rate0 second", code_out, 12'h066);

        // overflow with reserved trigger
        do_reset();
        start_mode = 2'b11; op_mode = 2'b00; rate = 8'd0;
        for (int i = 1; i <= 8; i++) write_word(16'(i << 8));
        chk("R9 full", fifo_full, 1);
        chk("R10 no overflow", overflow, 0);
        chk("R12 idle", code_valid, 0);
        write_word(16'hF000);
        chk("R10 overflow", overflow, 1);
        chk("R10 still full", fifo_full, 1);
        start_mode = 2'b00;
        repeat (12) @(negedge clk);
        chk("R9 R10 last kept", code_out, 12'h080);
        chk("R9 empty", fifo_empty, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule